// File: doc/BRIEF.md
# Programmable CRC Checksum Engine

This block computes a running CRC over a stream of data beats. Software chooses the polynomial (16-bit CCITT or 32-bit Ethernet-style) and the beat width (8, 16 or 32 bits). It also chooses where beats come from. A beat can be a processor write to a data register. It can instead be a strobe from one chosen DMA channel, which arrives on a valid, channel-number and data port. The checksum register can be written, so software can seed it. Software reads the same register to get the result. No final inversion is applied to the result.

A beat is absorbed one byte per clock, lowest byte first, so a full word occupies the engine for four cycles. A busy flag guards ownership of the engine. In register-fed mode, enabling the engine claims it. Software releases it by writing one to the busy bit after reading the checksum. The configuration register is frozen while the engine is enabled or busy. Disabling the engine takes two writes: clear the enable bit, then write zero to the configuration register.

Top module: `crc_engine`

## Requirements
- R1: The register map is: configuration at address 0, global control at 1 (bit 0 enables), data-in at 2, checksum at 3, status at 4 (bit 0 is busy). After reset, every register reads zero. This means the CCITT polynomial, byte beats, no source selected, disabled and idle.
- R2: Configuration bits [1:0] set the beat width: 0 absorbs the low 8 bits, 1 the low 16 bits and 2 all 32 bits. Code 3 acts as 0. Bytes are absorbed lowest first, one per clock, and the checksum is final four cycles after a beat is accepted.
- R3: Configuration bit 2 = 1 selects CRC-32, computed LSB-first (reflected) with polynomial 0x04C11DB7. Seeded with 0xFFFFFFFF, the ASCII bytes "123456789" leave 0x340BC6D9 in the checksum register.
- R4: Configuration bit 2 = 0 selects CRC-16 CCITT, computed MSB-first with polynomial 0x1021. Seeded with 0xFFFF, "123456789" leaves 0x29B1. In this mode checksum bits [31:16] read zero.
- R5: Configuration bits [13:8] hold the source. The value 0x01 selects register-fed mode, in which each write to data-in is one beat. The value 0x20+n selects DMA channel n, in which only a strobe whose channel number equals n is a beat. Data-in writes and strobes from other channels have no effect.
- R6: A write to the configuration register is ignored while the engine is enabled or busy.
- R7: The busy bit reads one from the moment a register-fed engine is enabled, and also while bytes of a beat remain. Writing one to it releases the claim when no beat is in flight. A write of one to the enable bit is ignored while busy reads one.
- R8: The checksum register accepts a seed write whenever no beat is in flight. While the engine is disabled, no beat is absorbed.
- R9: A beat that arrives while a previous beat still has bytes left is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dma_valid | input | 1 | DMA beat strobe |
| dma_chan | input | 5 | Channel number of the DMA beat |
| dma_data | input | 32 | DMA beat data |

## Verification
The bench checks the standard "123456789" vectors for both polynomials, then random seeds and beats at every width including the reserved code, against a bitwise model. A design that processed bytes in the wrong order, or the wrong number of bytes, would produce a wrong checksum. Strobes from a foreign channel, data-in writes in channel mode, and beats while disabled must all leave the checksum unchanged; an engine that absorbed any of them would give a different value. A second beat sent during a word beat must be dropped, and so must a seed write made during a word beat. A design that let either through would corrupt the result. The bench also tries to reprogram the configuration and to re-enable while claimed. A design that failed to lock would read back the changed value.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int DATA_W = 32;
    localparam int CHAN_W = 5;
    localparam int SRC_W  = CHAN_W + 1;
    localparam int ADDR_W = 3;
    localparam int NBYTES = DATA_W / 8;
    localparam int CNT_W  = $clog2(NBYTES);

    localparam logic [SRC_W-1:0] SRC_REGFED = SRC_W'(1);

    localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_GCTL = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_DIN  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_SUM  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(4);

    typedef enum logic {
        POLY_CCITT16 = 1'b0,
        POLY_ETH32   = 1'b1
    } poly_e;

    typedef enum logic [1:0] {
        BEAT_8    = 2'd0,
        BEAT_16   = 2'd1,
        BEAT_32   = 2'd2,
        BEAT_RSVD = 2'd3
    } beat_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        poly_e            poly;
        beat_e            beat;
    } cfg_t;

    // Bytes after the first one that a beat of this width carries
    function automatic logic [CNT_W-1:0] extra_bytes(input beat_e b);
        case (b)
            BEAT_16: extra_bytes = CNT_W'(1);
            BEAT_32: extra_bytes = CNT_W'(NBYTES - 1);
            default: extra_bytes = '0;
        endcase
    endfunction

    function automatic logic [15:0] ccitt_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
        end
        return x;
    endfunction

    function automatic logic [31:0] eth_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] x;
        x = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
        end
        return x;
    endfunction

    function automatic logic [DATA_W-1:0] crc_step(input poly_e p,
                                                   input logic [DATA_W-1:0] c,
                                                   input logic [7:0] d);
        if (p == POLY_ETH32) return eth_byte(c, d);
        return {16'h0000, ccitt_byte(c[15:0], d)};
    endfunction

endpackage

// File: rtl/crc_regs.sv
module crc_regs
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              in_flight,
    output cfg_t              cfg_q,
    output logic              en_q,
    output logic              claim_q,
    output logic              busy,
    output logic              din_wr,
    output logic              sum_wr
);

    logic cfg_wr, gctl_wr, stat_wr;
    logic grant_en;

    assign cfg_wr  = reg_wr && (reg_addr == ADR_CFG);
    assign gctl_wr = reg_wr && (reg_addr == ADR_GCTL);
    assign stat_wr = reg_wr && (reg_addr == ADR_STAT);
    assign din_wr  = reg_wr && (reg_addr == ADR_DIN);
    assign sum_wr  = reg_wr && (reg_addr == ADR_SUM);

    assign busy     = claim_q || in_flight;
    assign grant_en = gctl_wr && reg_wdata[0] && !en_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{src: '0, poly: POLY_CCITT16, beat: BEAT_8};
        end else if (cfg_wr && !en_q && !busy) begin
            cfg_q.beat <= beat_e'(reg_wdata[1:0]);
            cfg_q.poly <= poly_e'(reg_wdata[2]);
            cfg_q.src  <= reg_wdata[8 +: SRC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (gctl_wr) begin
            if (!reg_wdata[0]) en_q <= 1'b0;
            else if (grant_en) en_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            claim_q <= 1'b0;
        end else if (grant_en && (cfg_q.src == SRC_REGFED)) begin
            claim_q <= 1'b1;
        end else if (stat_wr && reg_wdata[0] && !in_flight) begin
            claim_q <= 1'b0;
        end
    end

endmodule

// File: rtl/crc_src_sel.sv
module crc_src_sel
    import crc_pkg::*;
(
    input  cfg_t              cfg_q,
    input  logic              en_q,
    input  logic              in_flight,
    input  logic              din_wr,
    input  logic [DATA_W-1:0] din_data,
    input  logic              dma_valid,
    input  logic [CHAN_W-1:0] dma_chan,
    input  logic [DATA_W-1:0] dma_data,
    output logic              beat_go,
    output logic [DATA_W-1:0] beat_data
);

    logic regfed_mode, chan_mode, chan_hit;

    assign regfed_mode = (cfg_q.src == SRC_REGFED);
    assign chan_mode   = cfg_q.src[SRC_W-1];
    assign chan_hit    = chan_mode && dma_valid && (cfg_q.src[CHAN_W-1:0] == dma_chan);

    always_comb begin
        beat_go   = 1'b0;
        beat_data = '0;
        if (en_q && !in_flight) begin
            if (regfed_mode && din_wr) begin
                beat_go   = 1'b1;
                beat_data = din_data;
            end else if (chan_hit) begin
                beat_go   = 1'b1;
                beat_data = dma_data;
            end
        end
    end

endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg_q,
    input  logic              beat_go,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              sum_wr,
    input  logic [DATA_W-1:0] sum_wdata,
    output logic [DATA_W-1:0] sum_q,
    output logic [CNT_W-1:0]  rem_q,
    output logic              in_flight
);

    logic [DATA_W-9:0] pend_q;

    assign in_flight = (rem_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            rem_q  <= '0;
            pend_q <= '0;
        end else if (beat_go) begin
            sum_q  <= crc_step(cfg_q.poly, sum_q, beat_data[7:0]);
            pend_q <= beat_data[DATA_W-1:8];
            rem_q  <= extra_bytes(cfg_q.beat);
        end else if (in_flight) begin
            sum_q  <= crc_step(cfg_q.poly, sum_q, pend_q[7:0]);
            pend_q <= pend_q >> 8;
            rem_q  <= rem_q - CNT_W'(1);
        end else if (sum_wr) begin
            sum_q <= sum_wdata;
        end
    end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dma_valid,
    input  logic [CHAN_W-1:0] dma_chan,
    input  logic [DATA_W-1:0] dma_data
);

    cfg_t              cfg_q;
    logic              en_q, claim_q, busy;
    logic              din_wr, sum_wr;
    logic              beat_go, in_flight;
    logic [DATA_W-1:0] beat_data, sum_q;
    logic [CNT_W-1:0]  rem_q;

    crc_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_flight(in_flight), .cfg_q(cfg_q),
        .en_q(en_q), .claim_q(claim_q), .busy(busy),
        .din_wr(din_wr), .sum_wr(sum_wr)
    );

    crc_src_sel u_sel (
        .cfg_q(cfg_q), .en_q(en_q), .in_flight(in_flight),
        .din_wr(din_wr), .din_data(reg_wdata),
        .dma_valid(dma_valid), .dma_chan(dma_chan), .dma_data(dma_data),
        .beat_go(beat_go), .beat_data(beat_data)
    );

    crc_datapath u_dp (
        .clk(clk), .rst(rst), .cfg_q(cfg_q), .beat_go(beat_go),
        .beat_data(beat_data), .sum_wr(sum_wr), .sum_wdata(reg_wdata),
        .sum_q(sum_q), .rem_q(rem_q), .in_flight(in_flight)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CFG: begin
                reg_rdata[1:0]         = cfg_q.beat;
                reg_rdata[2]           = cfg_q.poly;
                reg_rdata[8 +: SRC_W]  = cfg_q.src;
            end
            ADR_GCTL: reg_rdata[0] = en_q;
            ADR_SUM:  reg_rdata = (cfg_q.poly == POLY_ETH32) ? sum_q : {16'h0000, sum_q[15:0]};
            ADR_STAT: reg_rdata[0] = busy;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
    import crc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input cfg_t              cfg_q,
    input logic              en_q,
    input logic              claim_q,
    input logic              busy,
    input logic              beat_go,
    input logic [CNT_W-1:0]  rem_q,
    input logic [DATA_W-1:0] sum_q
);

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (en_q || busy) |=> $stable(cfg_q)); // R6

    AST_BYTE_BEAT_DONE: assert property (@(posedge clk) disable iff (rst)
        (beat_go && cfg_q.beat == BEAT_8) |=> (rem_q == '0)); // R2

    AST_WORD_BEAT_LEN: assert property (@(posedge clk) disable iff (rst)
        (beat_go && cfg_q.beat == BEAT_32) |=> (rem_q == CNT_W'(NBYTES - 1))); // R2

    AST_CLAIM_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADR_STAT && reg_wdata[0] && rem_q == '0 && !(reg_addr == ADR_GCTL))
        |=> !claim_q); // R7

    AST_NO_EN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!en_q && busy) |=> !en_q); // R7

    AST_SUM_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en_q && rem_q == '0 && !(reg_wr && reg_addr == ADR_SUM)) |=> $stable(sum_q)); // R8

endmodule

bind crc_engine crc_engine_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_q(cfg_q), .en_q(en_q), .claim_q(claim_q),
    .busy(busy), .beat_go(beat_go), .rem_q(rem_q), .sum_q(sum_q)
);

// File: tb/tb_crc_engine.sv
module tb_crc_engine;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_valid = 1'b0;
    logic [4:0]  dma_chan = '0;
    logic [31:0] dma_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    crc_engine dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_valid(dma_valid),
        .dma_chan(dma_chan), .dma_data(dma_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bitwise reference models (bit-serial with explicit feedback bit)
    function automatic logic [15:0] ref16(input logic [15:0] c, input logic [7:0] d);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [31:0] ref32(input logic [31:0] c, input logic [7:0] d);
        logic fb;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_beat(input bit poly32, input logic [1:0] width,
                                             input logic [31:0] c, input logic [31:0] d);
        int n;
        n = (width == 2'd1) ? 2 : (width == 2'd2) ? 4 : 1;
        for (int i = 0; i < n; i++) begin
            if (poly32) c = ref32(c, d[8*i +: 8]);
            else        c = {16'h0, ref16(c[15:0], d[8*i +: 8])};
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic dma(input logic [4:0] ch, input logic [31:0] d);
        @(negedge clk);
        dma_valid = 1'b1; dma_chan = ch; dma_data = d;
        @(negedge clk);
        dma_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_off();
        wr(3'd4, 32'h1);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v, model;
        logic [7:0]  msg [9];
        void'($urandom(32'd2024));
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); check("R1 cfg", v, 32'h0);
        rd(3'd1, v); check("R1 gctl", v, 32'h0);
        rd(3'd3, v); check("R1 sum", v, 32'h0);
        rd(3'd4, v); check("R1 stat", v, 32'h0);

        // R3 CRC-32 check string, register-fed, byte beats
        wr(3'd0, 32'h0000_0104);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, 32'h1);
        rd(3'd4, v); check("R7 busy after regfed enable", v, 32'h1);
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, v); check("R6 cfg locked", v, 32'h0000_0104);
        for (int i = 0; i < 9; i++) begin wr(3'd2, {24'h0, msg[i]}); idle(4); end
        rd(3'd3, v); check("R3 crc32 check value", v, 32'h340B_C6D9);
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R7 w1c releases", v, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0);
        rd(3'd0, v); check("R6 cfg clear after disable", v, 32'h0);

        // R4 CRC-16 check string
        wr(3'd0, 32'h0000_0100);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, 32'h1);
        for (int i = 0; i < 9; i++) begin wr(3'd2, {24'h0, msg[i]}); idle(4); end
        rd(3'd3, v); check("R4 crc16 check value and upper zero", v, 32'h0000_29B1);
        // R7 enable refused while claimed
        wr(3'd1, 32'h0);
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R7 enable refused while busy", v, 32'h0);
        release_off();

        // R2 random widths, polys, seeds
        for (int t = 0; t < 8; t++) begin
            bit poly32;
            logic [1:0] w;
            poly32 = 1'($urandom);
            w      = 2'(t % 4);
            wr(3'd0, 32'h0000_0100 | {29'h0, poly32, w});
            model = $urandom;
            wr(3'd3, model);
            wr(3'd1, 32'h1);
            for (int b = 0; b < 5; b++) begin
                logic [31:0] d;
                d = $urandom;
                model = ref_beat(poly32, w, model, d);
                wr(3'd2, d);
                idle(4);
            end
            if (!poly32) model[31:16] = 16'h0;
            rd(3'd3, v); check($sformatf("R2 random width %0d", w), v, model);
            release_off();
        end

        // R9 back-to-back beat dropped; R8 seed write mid-beat dropped
        wr(3'd0, 32'h0000_0106);
        wr(3'd3, 32'h1234_5678);
        wr(3'd1, 32'h1);
        model = ref_beat(1'b1, 2'd2, 32'h1234_5678, 32'hA5A5_0F0F);
        wr(3'd2, 32'hA5A5_0F0F);
        wr(3'd2, 32'hDEAD_BEEF);
        idle(4);
        rd(3'd3, v); check("R9 beat during flight dropped", v, model);
        model = ref_beat(1'b1, 2'd2, model, 32'h0BAD_F00D);
        wr(3'd2, 32'h0BAD_F00D);
        wr(3'd3, 32'h0);
        idle(4);
        rd(3'd3, v); check("R8 seed during flight dropped", v, model);
        release_off();

        // R5 channel mode, channel 3
        wr(3'd0, 32'h0000_2306);
        wr(3'd3, 32'hCAFE_0001);
        dma(5'd3, 32'h1111_2222);
        idle(4);
        rd(3'd3, v); check("R8 no beat while disabled", v, 32'hCAFE_0001);
        wr(3'd1, 32'h1);
        rd(3'd4, v); check("R7 channel mode not claimed", v, 32'h0);
        dma(5'd5, 32'h3333_4444);
        idle(4);
        wr(3'd2, 32'h5555_6666);
        idle(4);
        rd(3'd3, v); check("R5 foreign channel and din ignored", v, 32'hCAFE_0001);
        model = ref_beat(1'b1, 2'd2, 32'hCAFE_0001, 32'h7777_8888);
        dma(5'd3, 32'h7777_8888);
        idle(4);
        rd(3'd3, v); check("R5 selected channel absorbed", v, model);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule